// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block buffers a stream of words between a write clock domain and a read clock domain. Words enter through a valid/ready port on the write clock and leave through the read port on the read clock. The write and read positions each cross to the other domain as Gray code through a two-stage synchronizer. Each domain works out the occupancy from its own position and the synchronized far position. From that occupancy it derives full, empty, a low-water flag, a high-water flag and a half-full flag. All three level flags are active low.

A mode pin selects the read behaviour. In standard mode a read request pops one word, and the word appears on the output one edge later as a single-cycle valid pulse. In fall-through mode the head word is loaded into the output register without any request and stays there until the consumer takes it. That register adds one word of capacity. The low-water and high-water flags can each run synchronously in their own domain, or asynchronously: one clock drives the flag active and the other releases it. The offsets come from parameters at reset and can be reloaded through a load strobe.

Back-pressure: the write side takes a word only on a write edge where `in_valid` and `in_ready` are both high. `in_ready` is low while the FIFO is full, and the source may change or withdraw its word while the port is stalled. On the read side, `out_ready` acts as the read request. In fall-through mode, a word with `out_valid` high stays unchanged on `out_data` until an edge where `out_ready` is high. Mode, flag style and offsets are quasi-static: change them only during reset, or with `ofs_load`.

Top module: `cdc_flag_fifo`

## Requirements
- R1: On each write edge with in_valid and in_ready high, one word is stored. in_ready equals not full. full goes high when the write side sees D words in memory. A write attempt while full changes neither the stored data nor the write position.
- R2: In standard mode (fwft_en=0), an edge with out_ready high and empty low pops the oldest word. That word is on out_data with out_valid high for exactly the next cycle. empty is high when the read side sees no word in memory. A read while empty changes nothing.
- R3: In fall-through mode (fwft_en=1), the head word moves to out_data by itself and out_valid rises. The word and out_valid hold until an edge with out_ready high. empty equals not out_valid. Capacity is D+1 words.
- R4: Words leave in the order they were accepted, with their values unchanged.
- R5: With equal, phase-aligned clocks, empty falls after the third read edge after a write into an empty FIFO. In fall-through mode, out_valid rises one edge after that.
- R6: With synchronous low-water (ae_async=0), lowmark_n is updated on read edges. It is low when the memory holds n words or fewer, where n is the low offset. In standard mode that is n words held in total. In fall-through mode it is n+1 words, counting the word in the output register.
- R7: With synchronous high-water (af_async=0), highmark_n is updated on write edges. It is low when the memory holds D−m words or more, where m is the high offset.
- R8: With ae_async=1, lowmark_n is driven low on a read edge and released high on a write edge. With af_async=1, highmark_n is driven low on a write edge and released high on a read edge. The thresholds are the same as in R6 and R7.
- R9: half_n goes low on the write edge after which the memory holds more than D/2 words. It goes high on the read edge after which the memory holds D/2 or fewer. From reset with no reads, that takes D/2+1 writes in standard mode and D/2+2 writes in fall-through mode.
- R10: Reset clears both positions, sets empty high and full low, sets out_valid low, sets lowmark_n low, and sets highmark_n and half_n high. It loads both offsets with their defaults (2 and 2).
- R11: An edge with ofs_load high loads ae_ofs_in as n and af_ofs_in as m in both domains. The new values take effect from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fwft_en | input | 1 | 1 selects fall-through read mode |
| ae_async | input | 1 | 1 selects two-clock low-water flag |
| af_async | input | 1 | 1 selects two-clock high-water flag |
| ofs_load | input | 1 | Load strobe for both offsets |
| ae_ofs_in | input | AW+1 | New low offset n |
| af_ofs_in | input | AW+1 | New high offset m |
| in_valid | input | 1 | Write word present |
| in_ready | output | 1 | FIFO can take a word |
| in_data | input | DW | Write word |
| out_ready | input | 1 | Read request / consumer ready |
| out_valid | output | 1 | out_data holds a read word |
| out_data | output | DW | Read word |
| empty | output | 1 | No word available (fall-through: not out_valid) |
| full | output | 1 | Memory holds D words |
| lowmark_n | output | 1 | Low-water flag, active low |
| highmark_n | output | 1 | High-water flag, active low |
| half_n | output | 1 | Half-full flag, active low |

## Verification
The bench drives both clocks from one 125 MHz source, so every crossing has a fixed latency. full, in_ready and the synchronous high-water flag change one write edge after the write that causes them. empty, out_valid, out_data and the synchronous low-water flag change one read edge after a pop. A word becomes visible to the far side three edges after the edge that moved the pointer, and in fall-through mode it reaches the output register one edge after that. A behavioural model computes these same edge counts with queues and integer positions. Outputs are compared against the model at every falling edge, halfway between updates, so each result is checked in the cycle it is due and not later.

// File: rtl/cdc_fifo_pkg.sv
package cdc_fifo_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/ptr_sync.sv
module ptr_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  // two flops; only Gray code is passed, so at most one bit is in flight
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/xdom_flag.sv
module xdom_flag #(
  parameter bit INIT_ON = 1'b0
) (
  input  logic set_clk,
  input  logic clr_clk,
  input  logic rst_n,
  input  logic set_cond,
  input  logic clr_cond,
  output logic flag_on
);

  logic t_set;
  logic t_clr;

  assign flag_on = t_set ^ t_clr;

  // set side flips its toggle only while the flag is off
  always_ff @(posedge set_clk or negedge rst_n) begin
    if (!rst_n)                    t_set <= INIT_ON;
    else if (set_cond && !flag_on) t_set <= ~t_set;
  end

  // clear side flips its toggle only while the flag is on
  always_ff @(posedge clr_clk or negedge rst_n) begin
    if (!rst_n)                   t_clr <= 1'b0;
    else if (clr_cond && flag_on) t_clr <= ~t_clr;
  end

endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl
  import cdc_fifo_pkg::*;
#(
  parameter int AW     = 4,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [AW:0]   rgray_sync,
  input  logic          ofs_load,
  input  logic [AW:0]   ae_in,
  input  logic [AW:0]   af_in,
  output logic          full_q,
  output logic          wr_en,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray_q,
  output logic [AW:0]   wcnt_nx,
  output logic [AW:0]   ae_ofs,
  output logic [AW:0]   af_ofs,
  output logic          paf_q
);

  localparam int          CW      = AW + 1;
  localparam int          DEPTH   = 1 << AW;
  localparam logic [CW:0] DEPTH_X = (CW+1)'(DEPTH);

  logic [CW-1:0] wbin;
  logic [CW-1:0] wbin_nx;
  logic [CW-1:0] rbin_s;
  logic [CW:0]   hi_sum;

  assign wr_en   = push_req & ~full_q;
  assign waddr   = wbin[AW-1:0];
  assign wbin_nx = wbin + {{(CW-1){1'b0}}, wr_en};
  assign rbin_s  = CW'(gray_to_bin(32'(rgray_sync)));
  assign wcnt_nx = wbin_nx - rbin_s;
  assign hi_sum  = {1'b0, wcnt_nx} + {1'b0, af_ofs};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin    <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      paf_q   <= 1'b1;
    end else begin
      wbin    <= wbin_nx;
      wgray_q <= CW'(bin_to_gray(32'(wbin_nx)));
      full_q  <= (wcnt_nx == DEPTH_X[CW-1:0]);
      paf_q   <= !(hi_sum >= DEPTH_X);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_ofs <= CW'(AE_DEF);
      af_ofs <= CW'(AF_DEF);
    end else if (ofs_load) begin
      ae_ofs <= ae_in;
      af_ofs <= af_in;
    end
  end

  a_r1_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && push_req) |=> (wbin == $past(wbin)));

  a_r7_full_implies_high: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> !paf_q);

endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
  import cdc_fifo_pkg::*;
#(
  parameter int AW     = 4,
  parameter int DW     = 8,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          pop_req,
  input  logic [AW:0]   wgray_sync,
  input  logic          ofs_load,
  input  logic [AW:0]   ae_in,
  input  logic [AW:0]   af_in,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray_q,
  output logic [AW:0]   rcnt_nx,
  output logic [AW:0]   ae_ofs,
  output logic [AW:0]   af_ofs,
  output logic          mem_empty_q,
  output logic          pae_q,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);

  localparam int CW = AW + 1;

  rd_mode_e      mode;
  logic [CW-1:0] rbin;
  logic [CW-1:0] rbin_nx;
  logic [CW-1:0] wbin_s;
  logic          pop;
  logic          hold_nx;

  assign mode    = fwft ? MODE_FWFT : MODE_STD;
  assign raddr   = rbin[AW-1:0];
  assign wbin_s  = CW'(gray_to_bin(32'(wgray_sync)));

  // standard: pop on request; fall-through: pop whenever the stage is free or being emptied
  assign pop     = !mem_empty_q &&
                   ((mode == MODE_FWFT) ? (!out_valid || pop_req) : pop_req);
  assign rbin_nx = rbin + {{(CW-1){1'b0}}, pop};
  assign rcnt_nx = wbin_s - rbin_nx;
  assign hold_nx = (mode == MODE_FWFT) ? (out_valid && !pop_req) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin        <= '0;
      rgray_q     <= '0;
      mem_empty_q <= 1'b1;
      pae_q       <= 1'b0;
    end else begin
      rbin        <= rbin_nx;
      rgray_q     <= CW'(bin_to_gray(32'(rbin_nx)));
      mem_empty_q <= (rcnt_nx == '0);
      pae_q       <= !(rcnt_nx <= ae_ofs);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= pop | hold_nx;
      if (pop) out_data <= rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_ofs <= CW'(AE_DEF);
      af_ofs <= CW'(AF_DEF);
    end else if (ofs_load) begin
      ae_ofs <= ae_in;
      af_ofs <= af_in;
    end
  end

  a_r2_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_empty_q && pop_req && out_valid == 1'b0 && !fwft) |=> (rbin == $past(rbin)));

  a_r2_std_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && pop_req && !mem_empty_q) |=> out_valid);

  a_r3_fwft_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft && out_valid && !pop_req) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/cdc_flag_fifo.sv
module cdc_flag_fifo #(
  parameter int AW     = 4,
  parameter int DW     = 8,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 2
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          fwft_en,
  input  logic          ae_async,
  input  logic          af_async,
  input  logic          ofs_load,
  input  logic [AW:0]   ae_ofs_in,
  input  logic [AW:0]   af_ofs_in,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          empty,
  output logic          full,
  output logic          lowmark_n,
  output logic          highmark_n,
  output logic          half_n
);

  localparam int          CW     = AW + 1;
  localparam int          DEPTH  = 1 << AW;
  localparam logic [CW:0] DEPTH_X = (CW+1)'(DEPTH);
  localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

  logic [DW-1:0] mem [DEPTH];

  logic          wr_en;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic [DW-1:0] rdata;
  logic [CW-1:0] wgray, rgray, wgray_r, rgray_w;
  logic [CW-1:0] wcnt_nx, rcnt_nx;
  logic [CW-1:0] ae_w, af_w, ae_r, af_r;
  logic          full_q, mem_empty_q, paf_q, pae_q;
  logic          ae_on, af_on, hf_on;
  logic [CW:0]   hi_w, hi_r;

  always_ff @(posedge wclk) begin
    if (wr_en) mem[waddr] <= in_data;
  end
  assign rdata = mem[raddr];

  fifo_wr_ctl #(.AW(AW), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_wr (
    .clk(wclk), .rst_n(rst_n), .push_req(in_valid), .rgray_sync(rgray_w),
    .ofs_load(ofs_load), .ae_in(ae_ofs_in), .af_in(af_ofs_in),
    .full_q(full_q), .wr_en(wr_en), .waddr(waddr), .wgray_q(wgray),
    .wcnt_nx(wcnt_nx), .ae_ofs(ae_w), .af_ofs(af_w), .paf_q(paf_q)
  );

  fifo_rd_ctl #(.AW(AW), .DW(DW), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_rd (
    .clk(rclk), .rst_n(rst_n), .fwft(fwft_en), .pop_req(out_ready),
    .wgray_sync(wgray_r), .ofs_load(ofs_load), .ae_in(ae_ofs_in),
    .af_in(af_ofs_in), .rdata(rdata), .raddr(raddr), .rgray_q(rgray),
    .rcnt_nx(rcnt_nx), .ae_ofs(ae_r), .af_ofs(af_r),
    .mem_empty_q(mem_empty_q), .pae_q(pae_q), .out_valid(out_valid),
    .out_data(out_data)
  );

  ptr_sync #(.W(CW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_r));
  ptr_sync #(.W(CW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_w));

  assign hi_w = {1'b0, wcnt_nx} + {1'b0, af_w};
  assign hi_r = {1'b0, rcnt_nx} + {1'b0, af_r};

  // low-water: activated from the read side, released from the write side
  xdom_flag #(.INIT_ON(1'b1)) u_lowmark (
    .set_clk(rclk), .clr_clk(wclk), .rst_n(rst_n),
    .set_cond(rcnt_nx <= ae_r), .clr_cond(wcnt_nx > ae_w), .flag_on(ae_on)
  );

  // high-water: activated from the write side, released from the read side
  xdom_flag #(.INIT_ON(1'b0)) u_highmark (
    .set_clk(wclk), .clr_clk(rclk), .rst_n(rst_n),
    .set_cond(hi_w >= DEPTH_X), .clr_cond(hi_r < DEPTH_X), .flag_on(af_on)
  );

  xdom_flag #(.INIT_ON(1'b0)) u_half (
    .set_clk(wclk), .clr_clk(rclk), .rst_n(rst_n),
    .set_cond(wcnt_nx > HALF_C), .clr_cond(rcnt_nx <= HALF_C), .flag_on(hf_on)
  );

  assign in_ready   = !full_q;
  assign full       = full_q;
  assign empty      = fwft_en ? !out_valid : mem_empty_q;
  assign lowmark_n  = ae_async ? !ae_on : pae_q;
  assign highmark_n = af_async ? !af_on : paf_q;
  assign half_n     = !hf_on;

endmodule

// File: tb/cdc_flag_fifo_test.sv
module cdc_flag_fifo_test;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int D  = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          fwft_en = 1'b0, ae_async = 1'b0, af_async = 1'b0;
  logic          ofs_load = 1'b0;
  logic [AW:0]   ae_ofs_in = '0, af_ofs_in = '0;
  logic          in_valid = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready, out_valid, empty, full, lowmark_n, highmark_n, half_n;
  logic [DW-1:0] out_data;

  cdc_flag_fifo #(.AW(AW), .DW(DW)) uut (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .fwft_en(fwft_en),
    .ae_async(ae_async), .af_async(af_async), .ofs_load(ofs_load),
    .ae_ofs_in(ae_ofs_in), .af_ofs_in(af_ofs_in), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .empty(empty), .full(full),
    .lowmark_n(lowmark_n), .highmark_n(highmark_n), .half_n(half_n)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string ph = "";

  // behavioural reference model
  int wb, rb, sw1, sw2, sr1, sr2, aeo, afo;
  bit m_full, m_mempty, m_ov, m_paes_n, m_pafs_n, aeL, afL, hfL;
  logic [DW-1:0] m_dout;
  logic [DW-1:0] q[$];

  task automatic m_reset();
    wb = 0; rb = 0; sw1 = 0; sw2 = 0; sr1 = 0; sr2 = 0;
    aeo = 2; afo = 2;
    m_full = 0; m_mempty = 1; m_ov = 0; m_paes_n = 0; m_pafs_n = 1;
    aeL = 1; afL = 0; hfL = 0; m_dout = '0;
    q.delete();
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      int wr, pop, wbn, rbn, wc, rc;
      wr  = (in_valid && !m_full) ? 1 : 0;
      pop = (!m_mempty && (fwft_en ? (!m_ov || out_ready) : out_ready)) ? 1 : 0;
      wbn = wb + wr;
      rbn = rb + pop;
      wc  = wbn - sw2;
      rc  = sr2 - rbn;
      if (pop == 1) m_dout = q.pop_front();
      if (wr == 1) q.push_back(in_data);
      m_ov     = (pop == 1) ? 1'b1 : (fwft_en ? (m_ov && !out_ready) : 1'b0);
      m_full   = (wc == D);
      m_mempty = (rc == 0);
      m_paes_n = !(rc <= aeo);
      m_pafs_n = !(wc + afo >= D);
      aeL = aeL ? !(wc > aeo) : (rc <= aeo);
      afL = afL ? !(rc + afo < D) : (wc + afo >= D);
      hfL = hfL ? !(rc <= D / 2) : (wc > D / 2);
      sw2 = sw1; sw1 = rb; sr2 = sr1; sr1 = wb;
      wb = wbn; rb = rbn;
      if (ofs_load) begin aeo = int'(ae_ofs_in); afo = int'(af_ofs_in); end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s%s: actual %0h expected %0h at %0t", tag, ph, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R1 in_ready", 32'(in_ready), 32'(!m_full));
    chk("R1 full", 32'(full), 32'(m_full));
    chk(fwft_en ? "R3 R5 out_valid" : "R2 R5 out_valid", 32'(out_valid), 32'(m_ov));
    chk(fwft_en ? "R3 R5 empty" : "R2 R5 empty", 32'(empty),
        32'(fwft_en ? !m_ov : m_mempty));
    if (m_ov) chk("R4 out_data", 32'(out_data), 32'(m_dout));
    chk(ae_async ? "R8 lowmark_n" : "R6 lowmark_n", 32'(lowmark_n),
        32'(ae_async ? !aeL : m_paes_n));
    chk(af_async ? "R8 highmark_n" : "R7 highmark_n", 32'(highmark_n),
        32'(af_async ? !afL : m_pafs_n));
    chk("R9 half_n", 32'(half_n), 32'(!hfL));
  endtask

  task automatic do_reset(input logic f, input logic aa, input logic fa);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; ofs_load = 1'b0;
    fwft_en = f; ae_async = aa; af_async = fa;
    m_reset();
    ph = " R10";
    for (int i = 0; i < 3; i++) begin @(negedge clk); cmp_all(); end
    rst_n = 1'b1;
    @(negedge clk); cmp_all();
    ph = "";
  endtask

  task automatic run(input int cycles, input int pw, input int pr);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      cmp_all();
      in_valid  = ($urandom % 100) < pw;
      out_ready = ($urandom % 100) < pr;
      in_data   = DW'($urandom);
    end
  endtask

  task automatic traffic();
    run(40, 100, 0);   // fill to full, R9 step count and R1 blocking
    run(40, 0, 100);   // drain to empty, R2/R3 ignored reads
    run(300, 60, 50);
    run(200, 85, 25);
    run(200, 25, 85);
    run(20, 0, 100);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    m_reset();
    do_reset(1'b0, 1'b0, 1'b0); traffic();
    do_reset(1'b1, 1'b0, 1'b0); traffic();
    do_reset(1'b0, 1'b1, 1'b1); traffic();
    do_reset(1'b1, 1'b1, 1'b1); traffic();
    // R11: load new offsets, then repeat traffic in both modes
    for (int k = 0; k < 2; k++) begin
      do_reset(k[0], 1'b0, 1'b1);
      ph = " R11";
      @(negedge clk); cmp_all();
      ofs_load = 1'b1; ae_ofs_in = 5'd5; af_ofs_in = 5'd4;
      @(negedge clk); cmp_all();
      ofs_load = 1'b0;
      traffic();
      ph = "";
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule